// File: doc/BRIEF.md
# Two-Ring Transmit Descriptor Engine

This block moves outgoing frames from memory to a byte stream. Software builds two circular rings of four-word descriptors, one for urgent traffic and one for normal traffic. It writes the head address of each ring into a pointer register, then writes a start command. The engine then goes once around each requested ring. For every descriptor that software has handed over, it streams the buffer out as one frame, clears the hand-over flag in memory and records a per-ring cause bit.

Memory is reached through a single-outstanding word master with a request/acknowledge handshake. Frames leave on a valid/ready byte stream that marks the final byte of each frame. When all commanded passes have finished, a level interrupt is raised if any cause bit that software has enabled is pending.

Register map (`reg_addr`):
- 0: normal ring pointer.
- 1: urgent ring pointer.
- 2: command.
- 3: interrupt enable.
- 4: cause acknowledge (the value written is ANDed into the cause bits).

Top module: `tx_ring_dma`

## Requirements
- R1: A pass starts at the ring pointer captured when the pass begins, and follows each descriptor's word 3 (byte offset 12) as the next address. It stops once that link equals the starting address. The descriptor fields are: word 0 is the status, with the hand-over flag at bit 31; word 1 holds the byte count in bits 31:16; word 2 holds a word-aligned buffer address.
- R2: A handed-over descriptor whose count is between 1 and 2047 is sent as one frame. Its bytes leave in ascending address order: byte k of each buffer word is taken from bits 8k+7:8k. `tx_last` is high only on the final byte.
- R3: A descriptor without the hand-over flag emits nothing, is not written, sets no cause bit, and the pass moves on to its link.
- R4: A handed-over descriptor whose count is 2048 or more, or zero, emits no bytes. It is still written back and still sets its cause bit.
- R5: Each handed-over descriptor has word 0 rewritten with bit 31 cleared and every other bit unchanged. This write happens after the frame's last byte.
- R6: Finishing a descriptor sets cause bit 3 for the normal ring or cause bit 2 for the urgent ring. A write to address 4 ANDs the cause bits with `reg_wdata[3:0]`.
- R7: Command bit 23 starts the urgent ring and bit 22 starts the normal ring. When both are set, the urgent pass completes before the normal pass begins. A command with neither bit set has no effect.
- R8: A command written while a pass is running is held and serviced once the running pass ends.
- R9: When the engine goes idle after a command that started a ring, `irq` rises if `cause & enable` is non-zero. `irq` falls once `cause & enable` becomes zero.
- R10: While `tx_valid` is stalled by `tx_ready` low, data and last stay stable. A memory request holds its address and direction until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 3 | register select |
| reg_wdata | input | 32 | register write data |
| cause | output | 4 | pending cause bits |
| irq | output | 1 | interrupt level |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | byte address, word aligned |
| mem_wdata | output | 32 | write data |
| mem_ack | input | 1 | request done; read data valid |
| mem_rdata | input | 32 | read data |
| tx_valid | output | 1 | frame byte valid |
| tx_data | output | 8 | frame byte |
| tx_last | output | 1 | final byte of frame |
| tx_ready | input | 1 | sink accepts byte |

## Verification
The bench builds a ring that mixes a sendable frame, a descriptor not handed over and an oversize descriptor. It checks three things: that the skipped entry stays untouched in memory, that the oversize entry is returned silently, and that byte order follows little-endian words. A design that stopped at the first unowned entry would leave the oversize status unchanged. A design that sent oversize frames would push unexpected bytes into the scoreboard.

Two further cases cover ordering. A both-bits command checks that urgent bytes precede normal bytes. A command issued under heavy backpressure mid-pass checks that a design dropping late commands loses the second frame. The bench also covers cause masking with an enable of zero, and the fall of `irq` after acknowledgement.

// File: rtl/tx_ring_dma.sv
module tx_ring_dma #(
  parameter int LEN_LIMIT = 2048,
  parameter int CNT_W     = 16,
  parameter int HI_BIT    = 23,
  parameter int LO_BIT    = 22
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [3:0]  cause,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LEN_LIMIT);

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_FETCH, S_EMIT, S_WB} st_t;
  st_t state;

  logic [31:0] ptr_lo, ptr_hi, cur, start, stat, baddr, nxt, word;
  logic [CNT_W-1:0] nbytes, remain;
  logic [1:0]  bidx;
  logic [3:0]  enable;
  logic        q, pend_lo, pend_hi, chk;

  wire cmd_wr   = reg_we && reg_addr == 3'd2;
  wire set_hi   = cmd_wr && reg_wdata[HI_BIT];
  wire set_lo   = cmd_wr && reg_wdata[LO_BIT];
  wire idle     = state == S_IDLE;
  wire take_hi  = idle && pend_hi;
  wire take_lo  = idle && !pend_hi && pend_lo;
  wire wb_done  = state == S_WB && mem_ack;
  wire fire     = tx_valid && tx_ready;
  wire hit      = |(cause & enable);
  wire [3:0] cause_set = wb_done ? (q ? 4'b0100 : 4'b1000) : 4'b0000;
  wire [3:0] cause_and = (reg_we && reg_addr == 3'd4) ? reg_wdata[3:0] : 4'hF;

  assign mem_req   = state inside {S_RD0, S_RD1, S_RD2, S_RD3, S_FETCH, S_WB};
  assign mem_we    = state == S_WB;
  assign mem_wdata = {1'b0, stat[30:0]};
  assign tx_valid  = state == S_EMIT;
  assign tx_data   = word[8*bidx +: 8];
  assign tx_last   = remain == CNT_W'(1);

  always_comb begin
    case (state)
      S_RD1:   mem_addr = cur + 32'd4;
      S_RD2:   mem_addr = cur + 32'd8;
      S_RD3:   mem_addr = cur + 32'd12;
      S_FETCH: mem_addr = baddr;
      default: mem_addr = cur;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_lo <= '0; ptr_hi <= '0; enable <= '0;
      pend_lo <= 1'b0; pend_hi <= 1'b0; chk <= 1'b0;
      cause <= '0; irq <= 1'b0;
    end else begin
      if (reg_we && reg_addr == 3'd0) ptr_lo <= reg_wdata;
      if (reg_we && reg_addr == 3'd1) ptr_hi <= reg_wdata;
      if (reg_we && reg_addr == 3'd3) enable <= reg_wdata[3:0];
      pend_hi <= (pend_hi && !take_hi) || set_hi;
      pend_lo <= (pend_lo && !take_lo) || set_lo;
      cause   <= (cause & cause_and) | cause_set;
      if (set_hi || set_lo) chk <= 1'b1;
      else if (idle && !pend_hi && !pend_lo && chk) chk <= 1'b0;
      if (idle && !pend_hi && !pend_lo && chk) irq <= hit;
      else if (!hit) irq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cur <= '0; start <= '0; stat <= '0; baddr <= '0;
      nxt <= '0; word <= '0; nbytes <= '0; remain <= '0; bidx <= '0; q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (take_hi || take_lo) begin
          q     <= take_hi;
          cur   <= take_hi ? ptr_hi : ptr_lo;
          start <= take_hi ? ptr_hi : ptr_lo;
          state <= S_RD0;
        end
        S_RD0: if (mem_ack) begin stat <= mem_rdata; state <= S_RD1; end
        S_RD1: if (mem_ack) begin nbytes <= mem_rdata[31:32-CNT_W]; state <= S_RD2; end
        S_RD2: if (mem_ack) begin baddr <= {mem_rdata[31:2], 2'b00}; state <= S_RD3; end
        S_RD3: if (mem_ack) begin
          nxt <= mem_rdata;
          if (!stat[31]) begin
            cur   <= mem_rdata;
            state <= (mem_rdata == start) ? S_IDLE : S_RD0;
          end else if (nbytes != '0 && nbytes < LIMIT) begin
            remain <= nbytes;
            state  <= S_FETCH;
          end else begin
            state <= S_WB;
          end
        end
        S_FETCH: if (mem_ack) begin
          word  <= mem_rdata;
          baddr <= baddr + 32'd4;
          bidx  <= 2'd0;
          state <= S_EMIT;
        end
        S_EMIT: if (fire) begin
          remain <= remain - CNT_W'(1);
          bidx   <= bidx + 2'd1;
          if (remain == CNT_W'(1)) state <= S_WB;
          else if (bidx == 2'd3) state <= S_FETCH;
        end
        S_WB: if (mem_ack) begin
          cur   <= nxt;
          state <= (nxt == start) ? S_IDLE : S_RD0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  a_r6_cause_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause[2]) |-> $past(mem_we && mem_ack && q));
  a_r6_cause_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause[3]) |-> $past(mem_we && mem_ack && !q));
  a_r9_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(state == S_IDLE));
  a_r5_wb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31] && mem_addr == cur);
endmodule

// File: tb/sim_tx_ring_dma.sv
module sim_tx_ring_dma;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0] cause;
  logic irq, mem_req, mem_we, mem_ack = 1'b0, tx_valid, tx_last, tx_ready = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [7:0] tx_data;
  logic bp_on = 1'b0;
  int total = 0, bad = 0, cyc = 0;
  logic [31:0] mem [0:1023];
  logic [8:0] expq [$];

  always #10 clk = ~clk;

  tx_ring_dma u0 (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .cause, .irq,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .tx_valid, .tx_data, .tx_last, .tx_ready);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tx_ready <= bp_on ? (cyc % 3 == 0) : 1'b1;
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[11:2]];
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (expq.size() == 0) check("R3/R4 unexpected byte", {23'd0, tx_last, tx_data}, 32'h1ff);
      else check("R2 stream byte", {23'd0, tx_last, tx_data}, {23'd0, expq.pop_front()});
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic desc(int a, logic [31:0] st, int n, int b, int nx);
    mem[a/4] = st; mem[a/4+1] = n << 16; mem[a/4+2] = b; mem[a/4+3] = nx;
  endtask

  task automatic frame(int b, int n, int seed);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v = 8'(seed + 7*i);
      mem[(b+i)/4][8*((b+i)%4) +: 8] = v;
      expq.push_back({i == n-1, v});
    end
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 20) begin
      @(negedge clk);
      quiet = (mem_req || tx_valid) ? 0 : quiet + 1;
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset tx_valid", {31'd0, tx_valid}, 0);
    check("reset mem_req", {31'd0, mem_req}, 0);
    check("R9 reset irq", {31'd0, irq}, 0);
    check("R6 reset cause", {28'd0, cause}, 0);

    // R1 R3 R4: owned frame, unowned skip, oversize
    desc(32'h100, 32'h8000_00A5, 5, 32'h400, 32'h110);
    desc(32'h110, 32'h0000_0011, 6, 32'h440, 32'h120);
    desc(32'h120, 32'h8000_0F00, 3000, 32'h480, 32'h100);
    frame(32'h400, 5, 8'h31);
    wr(3'd0, 32'h100); wr(3'd3, 32'h8); wr(3'd2, 32'h0040_0000);
    wait_idle();
    check("R2 all bytes seen", expq.size(), 0);
    check("R5 owned writeback", mem[32'h100/4], 32'h0000_00A5);
    check("R3 unowned untouched", mem[32'h110/4], 32'h0000_0011);
    check("R4 oversize returned", mem[32'h120/4], 32'h0000_0F00);
    check("R6 low cause", {28'd0, cause}, 32'h8);
    check("R9 irq raised", {31'd0, irq}, 1);
    wr(3'd4, 32'h0); repeat (3) @(negedge clk);
    check("R6 cause ack", {28'd0, cause}, 0);
    check("R9 irq falls", {31'd0, irq}, 0);

    // R7: both bits, urgent first; enable 0 -> no irq
    wr(3'd3, 32'h0);
    desc(32'h200, 32'h8000_0001, 7, 32'h600, 32'h200);
    desc(32'h100, 32'h8000_0002, 4, 32'h500, 32'h110);
    mem[32'h120/4] = 32'h0000_0F00;
    frame(32'h600, 7, 8'h90);
    frame(32'h500, 4, 8'h05);
    wr(3'd1, 32'h200); wr(3'd2, 32'h00C0_0000);
    wait_idle();
    check("R7 order bytes consumed", expq.size(), 0);
    check("R6 both causes", {28'd0, cause}, 32'hC);
    check("R9 masked no irq", {31'd0, irq}, 0);
    check("R5 high writeback", mem[32'h200/4], 32'h0000_0001);
    wr(3'd4, 32'h0);

    // R8 R10: command latched during backpressured pass
    bp_on = 1'b1;
    desc(32'h100, 32'h8000_0003, 9, 32'h540, 32'h110);
    mem[32'h200/4] = 32'h8000_0004;
    frame(32'h540, 9, 8'h40);
    frame(32'h600, 7, 8'hC3);
    wr(3'd2, 32'h0040_0000);
    repeat (6) @(negedge clk);
    wr(3'd2, 32'h0080_0000);
    wait_idle();
    bp_on = 1'b0;
    check("R8 latched pass done", expq.size(), 0);
    check("R8 high returned", mem[32'h200/4], 32'h0000_0004);
    check("R6 causes after R8", {28'd0, cause}, 32'hC);

    // R7: empty command does nothing
    wr(3'd4, 32'h0);
    mem[32'h100/4] = 32'h8000_0003;
    wr(3'd2, 32'h0000_0000);
    begin
      int seen = 0;
      repeat (20) begin @(negedge clk); if (mem_req) seen++; end
      check("R7 empty command idle", seen, 0);
    end
    check("R7 empty command no writeback", mem[32'h100/4], 32'h8000_0003);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule